// File: doc/BRIEF.md
# Flash command interface controller

This block is a cycle-based model of the command front end of a partitioned NOR flash. A host drives bus write cycles with an active-low chip enable, an active-low write enable, a block address and a command byte. The block decodes single-cycle commands (read array, read status, read lock configuration, clear status) and two-cycle commands (block erase, full chip erase, program, one-time-programmable program, lock configuration). Accepted erase and program operations go to one shared write engine. The engine does not hold a real array. It counts down a programmable number of busy cycles.

Each partition has its own read mode and its own 8-bit status register. Each block has a lock bit and a lock-down bit. Erase and program are refused when the target block is locked, when the supply-lockout flag is high, or while the engine is busy. A read of a partition that does not own the running operation still returns its array or configuration data. The read port is combinational: `rd_data` follows `rd_blk` and the current state in the same cycle.

Status bits: bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 supply-lockout error, bit 1 block-locked error, all other bits 0. A command sequence error is bit 5 and bit 4 together.

Top module: `fcmd_ctrl`

## Requirements
- R1: A bus write ends in the first clock cycle in which either `ce_n` or `we_n` is high after a cycle with both low. The block and data used are the values present in the last cycle with both low. Values that change together with the rising strobe are not used.
- R2: Command codes: 0xFF read array, 0x70 read status, 0x90 read lock configuration, 0x50 clear status, 0x20 block erase, 0x30 chip erase, 0x40 program, 0xC0 OTP program, 0x60 lock setup, 0xD0 confirm. The first cycle of a two-cycle command on its own changes no lock bit and does not start the engine.
- R3: While the engine runs, the owning partition reads back its status with bit 7 = 0. Every other partition keeps bit 7 = 1.
- R4: Error bits accumulate and are never cleared by any command except 0x50, which clears bits 6..0 of the addressed partition. A reset also clears them.
- R5: After reset all blocks are locked and none is locked down. Every partition is in read-array mode and returns 0xFF. Every status reads 0x80 and the engine is idle. Bus writes made while `rst_n` is low have no effect.
- R6: While `vpp_lockout` is high, erase, program and OTP program are refused with bit 3 plus the operation bit (5 for erase, 4 for program) and no busy time. Lock commands still take effect.
- R7: Block erase or program to a locked block, or chip erase while any block is locked, is refused with bit 1 plus the operation bit and no busy time.
- R8: A partition that does not own the running operation returns array data (0xFF) in read-array mode.
- R9: An erase or program confirmed while the engine is busy is rejected with a command sequence error in the addressed partition.
- R10: A wrong second cycle (not 0xD0 after 0x20 or 0x30; not 0x01, 0xD0 or 0x2F after 0x60) sets a command sequence error. The partition is left in read-status mode.
- R11: An accepted operation holds bit 7 of its partition at 0 for exactly `busy_cycles` clock cycles after the accepting cycle. A value of 0 counts as 1.
- R12: The lock-configuration read returns {6'b0, lock-down, lock} for the block. Lock-setup second cycle 0x01 locks, 0xD0 unlocks, 0x2F locks and locks down. Unlock has no effect on a locked-down block.
- R13: OTP program succeeds once per reset. A later attempt is refused with bit 1 plus bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset; refuses all writes while low |
| vpp_lockout | input | 1 | Programming-supply lockout flag |
| busy_cycles | input | BUSY_W | Engine busy time in cycles |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_blk | input | BLK_W | Block index of the bus write |
| wr_data | input | 8 | Command or data byte |
| rd_blk | input | BLK_W | Block index to read |
| rd_data | output | 8 | Read data for `rd_blk` |
| engine_busy | output | 1 | Shared write engine is counting |

## Verification
The status register is the main window on the decoder. A lost pending state, a wrong owner partition or a missed error bit shows up on the next status read of the addressed partition, one cycle after the write ends. A lock bit that is wrong appears in the lock-configuration read. It also appears one cycle later, when an erase to that block does or does not raise `engine_busy`. A busy counter that is off by one changes the number of status polls that return bit 7 = 0. The mismatch is therefore visible at the end of the operation.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] C_RD_STAT   = 8'h70;
  localparam logic [7:0] C_RD_LOCK   = 8'h90;
  localparam logic [7:0] C_CLR_STAT  = 8'h50;
  localparam logic [7:0] C_ERASE     = 8'h20;
  localparam logic [7:0] C_CHIP      = 8'h30;
  localparam logic [7:0] C_PROG      = 8'h40;
  localparam logic [7:0] C_OTP       = 8'hC0;
  localparam logic [7:0] C_LOCK      = 8'h60;
  localparam logic [7:0] C_CONFIRM   = 8'hD0;
  localparam logic [7:0] C_LK_SET    = 8'h01;
  localparam logic [7:0] C_LK_DOWN   = 8'h2F;

  localparam int SR_RDY  = 7;
  localparam int SR_ERS  = 5;
  localparam int SR_PRG  = 4;
  localparam int SR_VPP  = 3;
  localparam int SR_LKE  = 1;

  localparam logic [7:0] M_ERS = 8'h20;
  localparam logic [7:0] M_PRG = 8'h10;
  localparam logic [7:0] M_VPP = 8'h08;
  localparam logic [7:0] M_LKE = 8'h02;
  localparam logic [7:0] M_SEQ = 8'h30;

  localparam logic [1:0] MD_ARRAY = 2'd0;
  localparam logic [1:0] MD_STAT  = 2'd1;
  localparam logic [1:0] MD_LOCK  = 2'd2;

  typedef enum logic [1:0] {LK_NONE, LK_SET, LK_CLR, LK_DOWN} lk_op_e;
  typedef enum logic [2:0] {PD_NONE, PD_ERASE, PD_CHIP, PD_PROG, PD_OTP, PD_LOCK} pend_e;
endpackage

// File: rtl/fcmd_bus_capture.sv
module fcmd_bus_capture #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic [BLK_W-1:0] blk,
  input  logic [7:0]       data,
  output logic             stb,
  output logic [BLK_W-1:0] stb_blk,
  output logic [7:0]       stb_data
);
  logic active, act_q;
  assign active = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      stb_blk  <= '0;
      stb_data <= '0;
    end else begin
      act_q <= active;
      if (active) begin
        stb_blk  <= blk;
        stb_data <= data;
      end
    end
  end

  // first rising strobe ends the cycle; held values are used
  assign stb = act_q && !active;

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/fcmd_lock_bank.sv
module fcmd_lock_bank import fcmd_pkg::*; #(
  parameter int NBLK  = 8,
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lk_op_e           op,
  input  logic [BLK_W-1:0] idx,
  output logic [NBLK-1:0]  locked,
  output logic [NBLK-1:0]  down
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic lk_q, dn_q, hit;
    assign hit = (op != LK_NONE) && (idx == BLK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q <= 1'b1;
        dn_q <= 1'b0;
      end else if (hit) begin
        case (op)
          LK_SET:  lk_q <= 1'b1;
          LK_CLR:  if (!dn_q) lk_q <= 1'b0;
          LK_DOWN: begin lk_q <= 1'b1; dn_q <= 1'b1; end
          default: ;
        endcase
      end
    end
    assign locked[b] = lk_q;
    assign down[b]   = dn_q;

    a_r12_down_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
      dn_q |-> lk_q);
  end
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine #(
  parameter int BUSY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUSY_W-1:0] load,
  output logic              busy,
  output logic              done
);
  logic [BUSY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= (load == '0) ? BUSY_W'(1) : load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - BUSY_W'(1);
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == BUSY_W'(1));

  a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl import fcmd_pkg::*; #(
  parameter int NUM_PART     = 2,
  parameter int BLK_PER_PART = 4,
  parameter int BUSY_W       = 16,
  parameter int BLK_W        = $clog2(NUM_PART * BLK_PER_PART)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_lockout,
  input  logic [BUSY_W-1:0] busy_cycles,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [7:0]        wr_data,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic [7:0]        rd_data,
  output logic              engine_busy
);
  localparam int NBLK   = NUM_PART * BLK_PER_PART;
  localparam int PART_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;

  logic             stb;
  logic [BLK_W-1:0] s_blk;
  logic [7:0]       s_data;
  logic [PART_W-1:0] s_part, r_part;
  logic [NBLK-1:0]  lk_vec, dn_vec;
  logic             eng_start, eng_done;

  pend_e  pend_q, pend_d;
  lk_op_e lk_op;
  logic [NUM_PART-1:0][7:0] sr_q;
  logic [NUM_PART-1:0][1:0] mode_q;
  logic [PART_W-1:0] owner_q;
  logic              otp_used_q;

  logic [7:0] err_bits;
  logic       clr_sr, mode_we, otp_set;
  logic [1:0] mode_d;

  fcmd_bus_capture #(.BLK_W(BLK_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .blk(wr_blk),
    .data(wr_data), .stb(stb), .stb_blk(s_blk), .stb_data(s_data));

  fcmd_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .op(lk_op), .idx(s_blk),
    .locked(lk_vec), .down(dn_vec));

  fcmd_engine #(.BUSY_W(BUSY_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .load(busy_cycles),
    .busy(engine_busy), .done(eng_done));

  assign s_part = PART_W'(int'(s_blk) / BLK_PER_PART);
  assign r_part = PART_W'(int'(rd_blk) / BLK_PER_PART);

  // command decoder
  always_comb begin
    pend_d    = pend_q;
    err_bits  = '0;
    clr_sr    = 1'b0;
    mode_we   = 1'b0;
    mode_d    = MD_ARRAY;
    eng_start = 1'b0;
    otp_set   = 1'b0;
    lk_op     = LK_NONE;
    if (stb) begin
      if (pend_q == PD_NONE) begin
        case (s_data)
          C_RD_ARRAY: begin mode_we = 1'b1; mode_d = MD_ARRAY; end
          C_RD_STAT:  begin mode_we = 1'b1; mode_d = MD_STAT;  end
          C_RD_LOCK:  begin mode_we = 1'b1; mode_d = MD_LOCK;  end
          C_CLR_STAT: clr_sr = 1'b1;
          C_ERASE:    begin pend_d = PD_ERASE; mode_we = 1'b1; mode_d = MD_STAT; end
          C_CHIP:     begin pend_d = PD_CHIP;  mode_we = 1'b1; mode_d = MD_STAT; end
          C_PROG:     begin pend_d = PD_PROG;  mode_we = 1'b1; mode_d = MD_STAT; end
          C_OTP:      begin pend_d = PD_OTP;   mode_we = 1'b1; mode_d = MD_STAT; end
          C_LOCK:     begin pend_d = PD_LOCK;  mode_we = 1'b1; mode_d = MD_STAT; end
          default: ;
        endcase
      end else begin
        pend_d  = PD_NONE;
        mode_we = 1'b1;
        mode_d  = MD_STAT;
        case (pend_q)
          PD_ERASE, PD_CHIP: begin
            if (s_data != C_CONFIRM)       err_bits = M_SEQ;
            else if (engine_busy)          err_bits = M_SEQ;
            else if (vpp_lockout)          err_bits = M_VPP | M_ERS;
            else if ((pend_q == PD_ERASE) ? lk_vec[s_blk] : (|lk_vec))
                                           err_bits = M_LKE | M_ERS;
            else                           eng_start = 1'b1;
          end
          PD_PROG, PD_OTP: begin
            if (engine_busy)               err_bits = M_SEQ;
            else if (vpp_lockout)          err_bits = M_VPP | M_PRG;
            else if ((pend_q == PD_PROG) ? lk_vec[s_blk] : otp_used_q)
                                           err_bits = M_LKE | M_PRG;
            else begin
              eng_start = 1'b1;
              otp_set   = (pend_q == PD_OTP);
            end
          end
          PD_LOCK: begin
            case (s_data)
              C_LK_SET:  lk_op = LK_SET;
              C_CONFIRM: lk_op = LK_CLR;
              C_LK_DOWN: lk_op = LK_DOWN;
              default:   err_bits = M_SEQ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= PD_NONE;
      owner_q    <= '0;
      otp_used_q <= 1'b0;
      for (int p = 0; p < NUM_PART; p++) begin
        sr_q[p]   <= 8'h80;
        mode_q[p] <= MD_ARRAY;
      end
    end else begin
      pend_q <= pend_d;
      if (eng_start) owner_q <= s_part;
      if (otp_set)   otp_used_q <= 1'b1;
      for (int p = 0; p < NUM_PART; p++) begin
        if (stb && s_part == PART_W'(p)) begin
          if (clr_sr) sr_q[p][6:0] <= '0;
          else        sr_q[p][6:0] <= sr_q[p][6:0] | err_bits[6:0];
          if (mode_we)   mode_q[p] <= mode_d;
          if (eng_start) sr_q[p][SR_RDY] <= 1'b0;
        end
        if (eng_done && owner_q == PART_W'(p)) sr_q[p][SR_RDY] <= 1'b1;
      end
    end
  end

  // read mux: a busy partition always returns its status
  always_comb begin
    if (!sr_q[r_part][SR_RDY]) rd_data = sr_q[r_part];
    else begin
      case (mode_q[r_part])
        MD_STAT: rd_data = sr_q[r_part];
        MD_LOCK: rd_data = {6'b0, dn_vec[rd_blk], lk_vec[rd_blk]};
        default: rd_data = 8'hFF;
      endcase
    end
  end

  a_r3_owner_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |-> !sr_q[owner_q][SR_RDY]);

  a_r6_no_start_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engine_busy) |-> !$past(vpp_lockout));

  for (genvar gp = 0; gp < NUM_PART; gp++) begin : g_chk
    a_r4_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && clr_sr && s_part == PART_W'(gp)) |=>
        ((sr_q[gp][6:0] & $past(sr_q[gp][6:0])) == $past(sr_q[gp][6:0])));
  end
endmodule

// File: tb/tb_fcmd_ctrl.sv
module tb_fcmd_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vpp_lockout = 1'b0;
  logic [15:0] busy_cycles = 16'd5;
  logic        ce_n = 1'b1, we_n = 1'b1;
  logic [2:0]  wr_blk = '0, rd_blk = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        engine_busy;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  logic [2:0] q_addr[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  fcmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .vpp_lockout(vpp_lockout), .busy_cycles(busy_cycles),
    .ce_n(ce_n), .we_n(we_n), .wr_blk(wr_blk), .wr_data(wr_data),
    .rd_blk(rd_blk), .rd_data(rd_data), .engine_busy(engine_busy));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares just after each edge
  initial forever begin
    @(posedge clk); #1;
    while (q_exp.size() > 0) begin
      logic [2:0] a; logic [7:0] e; string t;
      a = q_addr.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      check($sformatf("%s blk%0d", t, a), rd_data, e);
    end
  end

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_blk = a;
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t);
    @(posedge clk); #2;
  endtask

  // kind 0: both strobes rise together; 1: data changes at the rise; 2: ce_n rises first
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input int kind = 0);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; wr_blk = a; wr_data = d;
    @(negedge clk);
    if (kind == 2) ce_n = 1'b1;
    else begin ce_n = 1'b1; we_n = 1'b1; end
    if (kind == 1) wr_data = 8'h00;
    @(posedge clk); #1;
    we_n = 1'b1;
  endtask

  task automatic count_busy(input logic [2:0] a, input int exp, input string t);
    int n = 0;
    rd_blk = a; #1;
    while (rd_data[7] == 1'b0 && n < 1000) begin
      n++; @(posedge clk); #1;
    end
    check(t, n, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (engine_busy && n < 5000) begin n++; @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R5: writes during reset are ignored
    repeat (2) @(negedge clk);
    bus_wr(3'd1, 8'h60);
    bus_wr(3'd1, 8'hD0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R5 engine idle", engine_busy, 0);
    exp_rd(3'd1, 8'hFF, "R5 array mode after reset");
    exp_rd(3'd5, 8'hFF, "R5 array mode p1");
    bus_wr(3'd1, 8'h90);
    exp_rd(3'd1, 8'h01, "R5 locked not down");
    bus_wr(3'd1, 8'h70);
    exp_rd(3'd1, 8'h80, "R5 status ready");

    // R2 first cycle alone; R10 wrong confirm
    bus_wr(3'd1, 8'h20);
    check("R2 no start on setup", engine_busy, 0);
    exp_rd(3'd1, 8'h80, "R2 status after setup");
    bus_wr(3'd1, 8'hFF);
    exp_rd(3'd1, 8'hB0, "R10 bad confirm seq error");
    bus_wr(3'd1, 8'h50);
    exp_rd(3'd1, 8'h80, "R4 clear status");
    bus_wr(3'd1, 8'h60);
    bus_wr(3'd1, 8'h99);
    exp_rd(3'd1, 8'hB0, "R10 bad lock confirm");
    bus_wr(3'd1, 8'h90);
    exp_rd(3'd1, 8'h01, "R10 lock unchanged");
    bus_wr(3'd1, 8'h50);

    // R7 locked block
    bus_wr(3'd1, 8'h20);
    bus_wr(3'd1, 8'hD0);
    check("R7 no busy on locked", engine_busy, 0);
    exp_rd(3'd1, 8'hA2, "R7 locked erase");
    bus_wr(3'd1, 8'h50);

    // R12 unlock
    bus_wr(3'd1, 8'h60);
    bus_wr(3'd1, 8'hD0);
    bus_wr(3'd1, 8'h90);
    exp_rd(3'd1, 8'h00, "R12 unlocked");

    // R1 capture with data changing at the rising strobe, R3, R8, R9
    busy_cycles = 16'd40;
    bus_wr(3'd1, 8'h20);
    bus_wr(3'd1, 8'hD0, 1);
    check("R1 held data confirmed", engine_busy, 1);
    exp_rd(3'd1, 8'h00, "R3 owner busy");
    exp_rd(3'd5, 8'hFF, "R8 other partition array");
    bus_wr(3'd5, 8'h70);
    exp_rd(3'd5, 8'h80, "R3 other partition ready");
    bus_wr(3'd1, 8'h40);
    bus_wr(3'd1, 8'h55);
    exp_rd(3'd1, 8'h30, "R9 busy reject");
    wait_idle();
    exp_rd(3'd1, 8'hB0, "R9 error kept after done");
    bus_wr(3'd1, 8'h50);

    // R11 busy length; R1 with ce_n rising first
    busy_cycles = 16'd5;
    bus_wr(3'd1, 8'h40);
    bus_wr(3'd1, 8'h12, 2);
    count_busy(3'd1, 5, "R11 busy 5");
    busy_cycles = 16'd0;
    bus_wr(3'd1, 8'h40);
    bus_wr(3'd1, 8'h12);
    count_busy(3'd1, 1, "R11 busy zero as one");
    exp_rd(3'd1, 8'h80, "R11 clean done");

    // R6 supply lockout
    vpp_lockout = 1'b1;
    bus_wr(3'd1, 8'h40);
    bus_wr(3'd1, 8'h12);
    check("R6 no busy in lockout", engine_busy, 0);
    exp_rd(3'd1, 8'h98, "R6 lockout program");
    bus_wr(3'd1, 8'h50);
    bus_wr(3'd1, 8'h60);
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd1, 8'h90);
    exp_rd(3'd1, 8'h01, "R6 lock works in lockout");
    vpp_lockout = 1'b0;

    // R12 lock-down
    bus_wr(3'd2, 8'h60);
    bus_wr(3'd2, 8'h2F);
    bus_wr(3'd2, 8'h90);
    exp_rd(3'd2, 8'h03, "R12 locked down");
    bus_wr(3'd2, 8'h60);
    bus_wr(3'd2, 8'hD0);
    bus_wr(3'd2, 8'h90);
    exp_rd(3'd2, 8'h03, "R12 unlock ignored");

    // R13 OTP once
    busy_cycles = 16'd3;
    bus_wr(3'd4, 8'hC0);
    bus_wr(3'd4, 8'h77);
    check("R13 first otp busy", engine_busy, 1);
    wait_idle();
    exp_rd(3'd4, 8'h80, "R13 first otp ok");
    bus_wr(3'd4, 8'hC0);
    bus_wr(3'd4, 8'h77);
    exp_rd(3'd4, 8'h92, "R13 second otp refused");
    bus_wr(3'd4, 8'hFF);
    bus_wr(3'd4, 8'h70);
    exp_rd(3'd4, 8'h92, "R4 error sticky");

    // R7 chip erase with locked blocks
    bus_wr(3'd6, 8'h30);
    bus_wr(3'd6, 8'hD0);
    check("R7 chip no busy", engine_busy, 0);
    exp_rd(3'd6, 8'hB2, "R7 chip erase locked");

    // R4/R5 reset clears errors
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_wr(3'd4, 8'h70);
    exp_rd(3'd4, 8'h80, "R4 reset clears errors");
    bus_wr(3'd2, 8'h90);
    exp_rd(3'd2, 8'h01, "R5 lock-down cleared by reset");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule